// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller turns single-word requests from a processor core into bus cycles on a narrow external memory bus. There are two 64 KB spaces, each addressed by 16 bits. The code space is read-only. The data space can be read and written. The low address byte and the data byte share one 8-bit bus and are separated in time. The high address byte has its own port. An active-high address strobe marks the interval in which an external transparent latch can capture the low address byte. After that interval, a code read strobe, a data read strobe or a data write strobe (each active low) frames the data transfer.

An active-low external-access input selects where code comes from. When the input is high, code fetches below the internal code size are served from an internal ROM port and cause no external bus activity. When it is low, every fetch goes to the external bus. Data accesses always go external.

Code fetches and data reads present the same address sequence and use different strobes. A board that combines both strobes onto one RAM can therefore run, as code, bytes that were earlier written as data.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, and while idle, `addr_stb` is 0, `code_rd_n`, `dat_rd_n` and `dat_wr_n` are 1, `mux_oe` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only when the controller is idle. A request held valid while the controller is busy is not taken until the controller is idle again.
- R3: An external cycle starts with ALE_CYC cycles in which `addr_stb` is 1, `mux_oe` is 1, `mux_out` carries address bits 7:0 and `addr_hi` carries address bits 15:8. `addr_hi` stays valid until the strobe ends.
- R4: One hold cycle follows the address phase. In it, `addr_stb` is 0, the low address is still driven on `mux_out`, and no read or write strobe is active.
- R5: `req_kind` encoding: 00 is a code fetch, 01 and 11 are data reads, 10 is a data write. An external code fetch holds `code_rd_n` low for STB_CYC cycles with `mux_oe` at 0. `mux_in` is sampled on the last of these cycles and appears on `rsp_rdata` in the following cycle, together with `rsp_done`.
- R6: A data read behaves like R5 but uses `dat_rd_n`, and `code_rd_n` stays high.
- R7: A data write holds `dat_wr_n` low for STB_CYC cycles. During those cycles `mux_out` carries the write data with `mux_oe` at 1. Write data never appears during the address or hold phase.
- R8: A code fetch with `ext_access_n` = 1 (sampled at acceptance) and address below INT_SIZE (default 4096) produces no external bus activity. `int_rd_en` is 1 for one cycle with `int_addr` set to the low address bits, and `int_rdata` from that cycle is returned with `rsp_done` in the next cycle. A fetch at or above INT_SIZE, or any fetch with `ext_access_n` = 0, goes external.
- R9: At most one of the three active-low strobes is low at any time, and none of them is low while `addr_stb` is 1.
- R10: A code fetch and a data access to the same address drive identical address phases. A byte written as data and then fetched as code from a shared external RAM is therefore returned unchanged.
- R11: `rsp_done` is a single-cycle pulse, issued exactly once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request can be accepted |
| req_kind | input | 2 | 00 fetch, 01/11 data read, 10 data write |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, valid with `rsp_done` on reads |
| rsp_done | output | 1 | One-cycle completion pulse |
| ext_access_n | input | 1 | 0: all code external; 1: low code internal |
| int_rd_en | output | 1 | Internal ROM read enable |
| int_addr | output | $clog2(INT_SIZE) | Internal ROM address |
| int_rdata | input | 8 | Internal ROM data |
| mux_out | output | 8 | Shared low-address/data bus, outgoing |
| mux_oe | output | 1 | Drive enable for the shared bus |
| mux_in | input | 8 | Shared bus, incoming |
| addr_hi | output | 8 | High address byte |
| addr_stb | output | 1 | Address latch strobe, active high |
| code_rd_n | output | 1 | Code read strobe, active low |
| dat_rd_n | output | 1 | Data read strobe, active low |
| dat_wr_n | output | 1 | Data write strobe, active low |

## Verification
The hardest situations to reach are two. The first is the boundary between internal and external code at INT_SIZE−1 and INT_SIZE. The second is a byte written through the data strobe and then read back through the code strobe. The bench models a small RAM that both read strobes reach through a transparent latch. It writes a byte, then fetches the same address with external access forced, so the returned value proves that the address phases match. Requests are also issued back to back with `req_valid` kept high across busy cycles, which exercises the hold-off at every phase.

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int ALE_CYC  = 2,
  parameter int STB_CYC  = 3,
  parameter int INT_SIZE = 4096,
  localparam int IAW = $clog2(INT_SIZE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_kind,
  input  logic [15:0]    req_addr,
  input  logic [7:0]     req_wdata,
  output logic [7:0]     rsp_rdata,
  output logic           rsp_done,
  input  logic           ext_access_n,
  output logic           int_rd_en,
  output logic [IAW-1:0] int_addr,
  input  logic [7:0]     int_rdata,
  output logic [7:0]     mux_out,
  output logic           mux_oe,
  input  logic [7:0]     mux_in,
  output logic [7:0]     addr_hi,
  output logic           addr_stb,
  output logic           code_rd_n,
  output logic           dat_rd_n,
  output logic           dat_wr_n
);
  localparam int CMAX = (ALE_CYC > STB_CYC) ? ALE_CYC : STB_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_HOLD, S_STRB, S_INT, S_DONE} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  kind_q;
  logic [15:0] addr_q;
  logic [7:0]  wdata_q, rdata_q;

  wire is_fetch = (kind_q == 2'b00);
  wire is_write = (kind_q == 2'b10);
  wire bus_act  = (st == S_ADDR) || (st == S_HOLD) || (st == S_STRB);
  wire wr_phase = (st == S_STRB) && is_write;
  wire go_int   = (req_kind == 2'b00) && ext_access_n && (32'(req_addr) < INT_SIZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          kind_q  <= req_kind;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (go_int) st <= S_INT;
          else begin
            st  <= S_ADDR;
            cnt <= CW'(ALE_CYC - 1);
          end
        end
        S_ADDR: if (cnt == '0) st <= S_HOLD;
                else cnt <= cnt - 1'b1;
        S_HOLD: begin
          st  <= S_STRB;
          cnt <= CW'(STB_CYC - 1);
        end
        S_STRB: if (cnt == '0) begin
          if (!is_write) rdata_q <= mux_in;
          st <= S_DONE;
        end else cnt <= cnt - 1'b1;
        S_INT: begin
          rdata_q <= int_rdata;
          st      <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_done  = (st == S_DONE);
  assign rsp_rdata = rdata_q;
  assign int_rd_en = (st == S_INT);
  assign int_addr  = addr_q[IAW-1:0];
  assign addr_stb  = (st == S_ADDR);
  assign addr_hi   = bus_act ? addr_q[15:8] : 8'h00;
  assign mux_oe    = (st == S_ADDR) || (st == S_HOLD) || wr_phase;
  assign mux_out   = wr_phase ? wdata_q :
                     ((st == S_ADDR) || (st == S_HOLD)) ? addr_q[7:0] : 8'h00;
  assign code_rd_n = !((st == S_STRB) && is_fetch);
  assign dat_rd_n  = !((st == S_STRB) && !is_fetch && !is_write);
  assign dat_wr_n  = !wr_phase;
endmodule

// File: rtl/ext_bus_ctrl_chk.sv
module ext_bus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_done,
  input logic addr_stb,
  input logic mux_oe,
  input logic code_rd_n,
  input logic dat_rd_n,
  input logic dat_wr_n,
  input logic int_rd_en
);
  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~code_rd_n, ~dat_rd_n, ~dat_wr_n}) <= 1);
  // R9
  stb_quiet_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |-> (code_rd_n && dat_rd_n && dat_wr_n));
  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_rd_n || !dat_rd_n) |-> !mux_oe);
  // R7
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr_n |-> mux_oe);
  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb || int_rd_en || rsp_done) |-> !req_ready);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R8
  int_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd_en |-> (!addr_stb && code_rd_n && !mux_oe));
  // R5
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_rd_n) |-> rsp_done);
endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk u_chk (.*);

// File: tb/tb_ext_bus_ctrl.sv
module tb_ext_bus_ctrl;
  localparam int ALE = 2, STB = 3, ISZ = 4096;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, rsp_done, ext_access_n = 1;
  logic [1:0] req_kind = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0, rsp_rdata, int_rdata, mux_out, mux_in, addr_hi;
  logic [11:0] int_addr;
  logic int_rd_en, mux_oe, addr_stb, code_rd_n, dat_rd_n, dat_wr_n;

  always #2 clk = ~clk;

  ext_bus_ctrl #(.ALE_CYC(ALE), .STB_CYC(STB), .INT_SIZE(ISZ)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .ext_access_n(ext_access_n),
    .int_rd_en(int_rd_en), .int_addr(int_addr), .int_rdata(int_rdata),
    .mux_out(mux_out), .mux_oe(mux_oe), .mux_in(mux_in), .addr_hi(addr_hi),
    .addr_stb(addr_stb), .code_rd_n(code_rd_n), .dat_rd_n(dat_rd_n), .dat_wr_n(dat_wr_n));

  // board: transparent latch + one RAM reached by both read strobes
  logic [7:0] ram [256];
  logic [7:0] lat = 0;
  assign mux_in    = (!code_rd_n || !dat_rd_n) ? ram[lat] : 8'hFF;
  assign int_rdata = int_addr[7:0] ^ 8'hC3;
  always @(negedge clk) begin
    if (addr_stb) lat = mux_out;
    if (!dat_wr_n) ram[lat] = mux_out;
  end

  int errs = 0, checks = 0;
  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model
  logic [7:0] exp_mem [256];
  bit busy = 0, intern = 0;
  int ph = 0;
  logic [1:0] m_kind = 0;
  logic [15:0] m_addr = 0;
  logic [7:0] m_wd = 0, m_rd = 0;
  initial for (int i = 0; i < 256; i++) begin
    ram[i] = 8'(i) ^ 8'h3C;
    exp_mem[i] = 8'(i) ^ 8'h3C;
  end

  always @(posedge clk) begin
    if (!rst_n) busy = 0;
    else if (busy) begin
      ph++;
      if (ph > (intern ? 1 : ALE + STB + 1)) busy = 0;
    end else if (req_valid) begin
      busy = 1; ph = 0;
      m_kind = req_kind; m_addr = req_addr; m_wd = req_wdata;
      intern = (req_kind == 2'b00) && ext_access_n && (int'(req_addr) < ISZ);
      if (req_kind == 2'b10) exp_mem[req_addr[7:0]] = req_wdata;
      m_rd = intern ? (req_addr[7:0] ^ 8'hC3) : exp_mem[req_addr[7:0]];
    end
  end

  always @(negedge clk) begin
    bit e_addr, e_hold, e_strb, e_int, e_done, wr;
    e_addr = busy && !intern && ph < ALE;
    e_hold = busy && !intern && ph == ALE;
    e_strb = busy && !intern && ph > ALE && ph <= ALE + STB;
    e_int  = busy && intern && ph == 0;
    e_done = busy && ph == (intern ? 1 : ALE + STB + 1);
    wr     = (m_kind == 2'b10);
    if (!rst_n) begin
      chk("R1", "addr_stb", addr_stb, 0);
      chk("R1", "strobes", {code_rd_n, dat_rd_n, dat_wr_n}, 3'b111);
      chk("R1", "mux_oe", mux_oe, 0);
      chk("R1", "ready", req_ready, 1);
      chk("R1", "done", rsp_done, 0);
    end else begin
      chk("R2", "req_ready", req_ready, !busy);
      chk("R3", "addr_stb", addr_stb, e_addr);
      chk("R3", "addr_hi", addr_hi, (e_addr || e_hold || e_strb) ? m_addr[15:8] : 0);
      chk("R4", "mux_oe", mux_oe, e_addr || e_hold || (e_strb && wr));
      if (e_addr || e_hold) chk("R4", "mux_out addr", mux_out, m_addr[7:0]);
      if (e_strb && wr) chk("R7", "mux_out wdata", mux_out, m_wd);
      chk("R5", "code_rd_n", code_rd_n, !(e_strb && m_kind == 2'b00));
      chk("R6", "dat_rd_n", dat_rd_n, !(e_strb && (m_kind == 2'b01 || m_kind == 2'b11)));
      chk("R7", "dat_wr_n", dat_wr_n, !(e_strb && wr));
      chk("R8", "int_rd_en", int_rd_en, e_int);
      if (e_int) chk("R8", "int_addr", int_addr, m_addr[11:0]);
      chk("R9", "strobe count", $countones({~code_rd_n, ~dat_rd_n, ~dat_wr_n}) <= 1, 1);
      chk("R11", "rsp_done", rsp_done, e_done);
      if (e_done && !wr) chk("R5", "rsp_rdata", rsp_rdata, m_rd);
    end
  end

  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output logic [7:0] v);
    while (!rsp_done) @(negedge clk);
    v = rsp_rdata;
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ext_access_n = 1;
    issue(2'b00, 16'h0123, 0); wait_done(v);         // R8 internal
    issue(2'b00, 16'h0FFF, 0); wait_done(v);         // R8 last internal
    issue(2'b00, 16'h1000, 0); wait_done(v);         // R8 first external
    issue(2'b10, 16'h2045, 8'hA7); wait_done(v);     // R7
    issue(2'b01, 16'h2045, 0); wait_done(v);         // R6
    issue(2'b01, 16'h0010, 0); wait_done(v);         // R6 data low address
    issue(2'b11, 16'h7F20, 0); wait_done(v);         // R5 kind 11 as read
    ext_access_n = 0;
    issue(2'b00, 16'h0100, 0); wait_done(v);         // R8 forced external
    issue(2'b10, 16'h5080, 8'h3E); wait_done(v);
    issue(2'b00, 16'h5080, 0); wait_done(v);
    chk("R10", "fetch of written byte", v, 8'h3E);
    ext_access_n = 1;
    // back to back with valid held across busy (R2)
    for (int i = 0; i < 24; i++)
      issue(2'(i % 3), 16'(i * 16'h0431 + 16'h0F00), 8'(i * 7 + 1));
    repeat (12) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule